// File: doc/BRIEF.md
# Interrupt Latch and Stacking Sequencer

This block sits between a set of peripheral interrupt requests and a small 8-bit processor core with a 16-bit address space. It keeps a single arbitration result: the lowest-numbered active request, captured while the processor's interrupt mask is clear. Once captured, that result is frozen. A later request of higher priority cannot displace it. Only two events release it: the interrupt is taken, or the mask bit drops from one to zero.

When the core issues an entry command, the block acknowledges the captured source. It then runs the bus itself, one byte per clock. It pushes five bytes of processor state onto a stack that grows downward, starting with the return address (program counter minus one), low byte first. It then reads a two-byte vector, high byte first. Finally it hands the new program counter, stack pointer and condition codes back to the core, with the mask bit set.

A return command runs the opposite sequence. It pulls the five bytes back in reverse order and hands them to the core.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, pending_o, bus_wr_o, bus_rd_o and irq_ack_o are all zero.
- R2: While mask_i is low, the lowest-numbered active request bit is captured, and pending_o rises one clock later.
- R3: A captured index is not replaced by any newly active request, of any priority, until it is taken or the mask falls.
- R4: While mask_i is high, nothing new is captured. A fall of mask_i releases a held capture, and re-arbitration captures the current winner one clock after the release.
- R5: An accepted entry command drives irq_ack_o one-hot, for one cycle, on the captured index. Other request bits that are still active are captured afterwards.
- R6: Entry writes five bytes on consecutive clocks at SP, SP-1, SP-2, SP-3 and SP-4. The bytes are, in that order: (PC-1)[7:0], (PC-1)[15:8], X, A, CCR.
- R7: After stacking, the vector high byte is read at VEC_BASE-2*index and the low byte at the next address. The loaded PC is {high, low}.
- R8: Entry completes with done_o high for exactly one cycle, 8 clocks after the command. At that point ld_sp_o is SP-5, ld_a_o and ld_x_o are unchanged, and ld_ccr_o is the input CCR with bit 3 (the mask bit) set.
- R9: A return command reads SP+1 through SP+5 on consecutive clocks, loading CCR, A, X, PC high and PC low in that order. done_o pulses 6 clocks after the command, and ld_sp_o is SP+5.
- R10: Entry and return commands that arrive while busy_o is high are ignored.
- R11: An entry command with nothing captured is ignored: no acknowledge and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 8 | Peripheral request bits, bit 0 highest priority |
| mask_i | input | 1 | Interrupt mask bit from the condition codes |
| take_i | input | 1 | Entry command |
| rti_i | input | 1 | Return command |
| cpu_pc_i | input | 16 | Current program counter |
| cpu_a_i | input | 8 | Accumulator |
| cpu_x_i | input | 8 | Index register |
| cpu_ccr_i | input | 8 | Condition codes |
| cpu_sp_i | input | 16 | Stack pointer |
| bus_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| irq_ack_o | output | 8 | One-hot acknowledge of the serviced source |
| pending_o | output | 1 | An arbitration result is captured |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| ld_pc_o | output | 16 | Program counter to load |
| ld_a_o | output | 8 | Accumulator to load |
| ld_x_o | output | 8 | Index register to load |
| ld_ccr_o | output | 8 | Condition codes to load |
| ld_sp_o | output | 16 | Stack pointer to load |

## Verification
The assertions check several rules on every cycle. The acknowledge is at most one-hot and always followed by busy. A captured index stays stable while nothing releases it. Push addresses step down by one and pull addresses step up by one. The bus is quiet while idle, and done never lasts two cycles. Only the directed scenarios show the rest: which source wins, that the frozen result survives a higher-priority arrival, the re-arbitration after a mask fall, the exact frame contents and vector addresses, the completion cycle counts, and that commands during a sequence are dropped.

// File: rtl/ils_pkg.sv
package ils_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_VECH = 3'd2,
    ST_VECL = 3'd3,
    ST_PULL = 3'd4
  } seq_state_e;

  localparam int unsigned FRAME_BYTES = 5;
endpackage

// File: rtl/ils_arbiter.sv
module ils_arbiter #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  // Lowest-numbered active bit wins: scan from the top so the lowest overwrites.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ils_latch.sv
module ils_latch #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_i,
  input  logic          any_i,
  input  logic [IW-1:0] win_i,
  input  logic          serviced_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic          valid_q, valid_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          mask_q;
  logic          release_w;

  assign release_w = mask_q && !mask_i;

  always_comb begin
    valid_n = valid_q;
    idx_n   = idx_q;
    if (serviced_i || (valid_q && release_w)) begin
      valid_n = 1'b0;
    end else if (!valid_q && !mask_i && any_i) begin
      valid_n = 1'b1;
      idx_n   = win_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      mask_q  <= 1'b1;
    end else begin
      valid_q <= valid_n;
      idx_q   <= idx_n;
      mask_q  <= mask_i;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  // R3: nothing but service or a mask fall may change a held result
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !serviced_i && !release_w) |=> (valid_q && $stable(idx_q)));
  // R4: no capture while masked
  assert_masked_no_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && mask_i) |=> !valid_q);
endmodule

// File: rtl/ils_seq.sv
module ils_seq
  import ils_pkg::*;
#(
  parameter int unsigned    IW       = 3,
  parameter logic [15:0]    VEC_BASE = 16'hFFFE,
  parameter int unsigned    MASK_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_ent_i,
  input  logic          go_rti_i,
  input  logic [IW-1:0] idx_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    a_i,
  input  logic [7:0]    x_i,
  input  logic [7:0]    ccr_i,
  input  logic [15:0]   sp_i,
  input  logic [7:0]    rdata_i,
  output logic [15:0]   addr_o,
  output logic [7:0]    wdata_o,
  output logic          wr_o,
  output logic          rd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [15:0]   pc_o,
  output logic [7:0]    a_o,
  output logic [7:0]    x_o,
  output logic [7:0]    ccr_o,
  output logic [15:0]   sp_o
);
  localparam logic [2:0] LAST = 3'(FRAME_BYTES - 1);

  seq_state_e    st_q, st_n;
  logic [2:0]    cnt_q, cnt_n;
  logic [15:0]   sp_q, sp_n, pc_q, pc_n;
  logic [7:0]    a_q, a_n, x_q, x_n, ccr_q, ccr_n;
  logic [IW-1:0] vidx_q, vidx_n;
  logic          done_q, done_n;
  logic [15:0]   vaddr_w;

  assign vaddr_w = VEC_BASE - (16'(vidx_q) << 1);

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sp_n = sp_q; pc_n = pc_q;
    a_n = a_q; x_n = x_q; ccr_n = ccr_q; vidx_n = vidx_q;
    done_n = 1'b0;
    addr_o = 16'h0000; wdata_o = 8'h00; wr_o = 1'b0; rd_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_ent_i) begin
          pc_n = pc_i - 16'd1; a_n = a_i; x_n = x_i; ccr_n = ccr_i;
          sp_n = sp_i; vidx_n = idx_i; cnt_n = '0; st_n = ST_PUSH;
        end else if (go_rti_i) begin
          sp_n = sp_i; cnt_n = '0; st_n = ST_PULL;
        end
      end
      ST_PUSH: begin
        addr_o = sp_q;
        wr_o   = 1'b1;
        unique case (cnt_q)
          3'd0:    wdata_o = pc_q[7:0];
          3'd1:    wdata_o = pc_q[15:8];
          3'd2:    wdata_o = x_q;
          3'd3:    wdata_o = a_q;
          default: wdata_o = ccr_q;
        endcase
        sp_n  = sp_q - 16'd1;
        cnt_n = cnt_q + 3'd1;
        if (cnt_q == LAST) begin
          ccr_n = ccr_q | (8'd1 << MASK_BIT);
          st_n  = ST_VECH;
        end
      end
      ST_VECH: begin
        addr_o = vaddr_w;
        rd_o   = 1'b1;
        pc_n[15:8] = rdata_i;
        st_n   = ST_VECL;
      end
      ST_VECL: begin
        addr_o = vaddr_w + 16'd1;
        rd_o   = 1'b1;
        pc_n[7:0] = rdata_i;
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      ST_PULL: begin
        addr_o = sp_q + 16'd1;
        rd_o   = 1'b1;
        sp_n   = sp_q + 16'd1;
        cnt_n  = cnt_q + 3'd1;
        unique case (cnt_q)
          3'd0:    ccr_n = rdata_i;
          3'd1:    a_n = rdata_i;
          3'd2:    x_n = rdata_i;
          3'd3:    pc_n[15:8] = rdata_i;
          default: pc_n[7:0] = rdata_i;
        endcase
        if (cnt_q == LAST) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sp_q <= '0; pc_q <= '0;
      a_q <= '0; x_q <= '0; ccr_q <= 8'd1 << MASK_BIT; vidx_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sp_q <= sp_n; pc_q <= pc_n;
      a_q <= a_n; x_q <= x_n; ccr_q <= ccr_n; vidx_q <= vidx_n;
      done_q <= done_n;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign pc_o = pc_q; assign a_o = a_q; assign x_o = x_q;
  assign ccr_o = ccr_q; assign sp_o = sp_q;

  // R6: consecutive pushes walk the stack downward
  assert_push_descends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && st_n == ST_PUSH) |=> (wr_o && addr_o == $past(addr_o) - 16'd1));
  // R9: consecutive pulls walk the stack upward
  assert_pull_ascends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULL && st_n == ST_PULL) |=> (rd_o && addr_o == $past(addr_o) + 16'd1));
  // R8: completion lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11: bus is quiet when no sequence runs
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wr_o && !rd_o));
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
  parameter int unsigned N_IRQ    = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFFE,
  parameter int unsigned MASK_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             mask_i,
  input  logic             take_i,
  input  logic             rti_i,
  input  logic [15:0]      cpu_pc_i,
  input  logic [7:0]       cpu_a_i,
  input  logic [7:0]       cpu_x_i,
  input  logic [7:0]       cpu_ccr_i,
  input  logic [15:0]      cpu_sp_i,
  input  logic [7:0]       bus_rdata_i,
  output logic [15:0]      bus_addr_o,
  output logic [7:0]       bus_wdata_o,
  output logic             bus_wr_o,
  output logic             bus_rd_o,
  output logic [N_IRQ-1:0] irq_ack_o,
  output logic             pending_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [15:0]      ld_pc_o,
  output logic [7:0]       ld_a_o,
  output logic [7:0]       ld_x_o,
  output logic [7:0]       ld_ccr_o,
  output logic [15:0]      ld_sp_o
);
  localparam int unsigned IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic          any_w, valid_w, go_ent_w, go_rti_w;
  logic [IW-1:0] win_w, idx_w;

  ils_arbiter #(.N_IRQ(N_IRQ)) u_arb (
    .req_i(irq_req_i), .any_o(any_w), .idx_o(win_w)
  );

  ils_latch #(.N_IRQ(N_IRQ)) u_latch (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .any_i(any_w), .win_i(win_w),
    .serviced_i(go_ent_w), .valid_o(valid_w), .idx_o(idx_w)
  );

  assign go_ent_w  = take_i && !busy_o && valid_w;
  assign go_rti_w  = rti_i && !busy_o && !take_i;
  assign irq_ack_o = go_ent_w ? (N_IRQ'(1) << idx_w) : '0;
  assign pending_o = valid_w;

  ils_seq #(.IW(IW), .VEC_BASE(VEC_BASE), .MASK_BIT(MASK_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_ent_i(go_ent_w), .go_rti_i(go_rti_w),
    .idx_i(idx_w), .pc_i(cpu_pc_i), .a_i(cpu_a_i), .x_i(cpu_x_i),
    .ccr_i(cpu_ccr_i), .sp_i(cpu_sp_i), .rdata_i(bus_rdata_i),
    .addr_o(bus_addr_o), .wdata_o(bus_wdata_o), .wr_o(bus_wr_o), .rd_o(bus_rd_o),
    .busy_o(busy_o), .done_o(done_o), .pc_o(ld_pc_o), .a_o(ld_a_o),
    .x_o(ld_x_o), .ccr_o(ld_ccr_o), .sp_o(ld_sp_o)
  );

  // R5: acknowledge names one source only
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack_o));
  // R5: an acknowledge always starts a sequence
  assert_ack_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o != '0) |=> busy_o);
  // R10: no acknowledge while a sequence runs
  assert_busy_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (irq_ack_o == '0));
endmodule

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] irq_req;
  logic mask, take, rti;
  logic [15:0] cpu_pc, cpu_sp;
  logic [7:0] cpu_a, cpu_x, cpu_ccr;
  logic [7:0] rdata;
  logic [15:0] addr, ld_pc, ld_sp;
  logic [7:0] wdata, ack, ld_a, ld_x, ld_ccr;
  logic wr, rd, pending, busy, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [logic [15:0]];

  always #5 clk = ~clk;

  irq_stack_seq i_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .mask_i(mask), .take_i(take),
    .rti_i(rti), .cpu_pc_i(cpu_pc), .cpu_a_i(cpu_a), .cpu_x_i(cpu_x),
    .cpu_ccr_i(cpu_ccr), .cpu_sp_i(cpu_sp), .bus_rdata_i(rdata),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_wr_o(wr), .bus_rd_o(rd),
    .irq_ack_o(ack), .pending_o(pending), .busy_o(busy), .done_o(done),
    .ld_pc_o(ld_pc), .ld_a_o(ld_a), .ld_x_o(ld_x), .ld_ccr_o(ld_ccr), .ld_sp_o(ld_sp)
  );

  function automatic logic [7:0] mrd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) rdata <= mrd(addr);
  always @(posedge clk) if (wr) mem[addr] = wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Issue an entry command and return the clocks until done and the ack seen.
  task automatic do_entry(input logic [15:0] pc, input logic [15:0] sp,
                          input logic [7:0] a, input logic [7:0] x, input logic [7:0] ccr,
                          output int n, output logic [7:0] ack_seen);
    @(negedge clk);
    cpu_pc = pc; cpu_sp = sp; cpu_a = a; cpu_x = x; cpu_ccr = ccr; take = 1'b1;
    #1 ack_seen = ack;
    irq_req = irq_req & ~ack;
    @(negedge clk); take = 1'b0; n = 1;
    while (!done && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    check(!busy && !done && !pending && !wr && !rd && ack == 8'h00, "R1", {busy, done, pending, wr, rd}, 0);
  endtask

  task automatic t_no_pending;
    irq_req = 8'h00; mask = 1'b0;
    @(negedge clk); take = 1'b1; #1;
    check(ack == 8'h00, "R11 ack", ack, 0);
    @(negedge clk); take = 1'b0;
    check(!busy && !wr && !rd, "R11 bus", {busy, wr, rd}, 0);
  endtask

  task automatic t_priority_entry;
    int n; logic [7:0] ak;
    mask = 1'b0; irq_req = 8'b0001_0100;
    mem[16'hFFFA] = 8'h12; mem[16'hFFFB] = 8'h34;
    cyc(1);
    check(pending, "R2 pending", pending, 1);
    do_entry(16'h8001, 16'h00F0, 8'hAA, 8'h55, 8'h01, n, ak);
    check(ak == 8'h04, "R2/R5 ack", ak, 8'h04);
    check(n == 8, "R8 cycles", n, 8);
    check(mrd(16'h00F0) == 8'h00 && mrd(16'h00EF) == 8'h80, "R6 return address", {mrd(16'h00EF), mrd(16'h00F0)}, 16'h8000);
    check(mrd(16'h00EE) == 8'h55 && mrd(16'h00ED) == 8'hAA && mrd(16'h00EC) == 8'h01, "R6 regs",
          {mrd(16'h00EE), mrd(16'h00ED), mrd(16'h00EC)}, 24'h55AA01);
    check(ld_pc == 16'h1234, "R7 vector", ld_pc, 16'h1234);
    check(ld_sp == 16'h00EB && ld_a == 8'hAA && ld_x == 8'h55, "R8 regs", ld_sp, 16'h00EB);
    check(ld_ccr == 8'h09, "R8 mask set", ld_ccr, 8'h09);
    cyc(1);
    check(!done, "R8 pulse", done, 0);
    // bit 4 still requests: captured afterwards
    check(pending, "R5 other kept", pending, 1);
  endtask

  task automatic t_freeze;
    int n; logic [7:0] ak;
    // idx 4 is captured from the previous scenario; a higher one arrives
    irq_req = irq_req | 8'h01;
    cyc(2);
    mem[16'hFFF6] = 8'h40; mem[16'hFFF7] = 8'h10;
    do_entry(16'h2000, 16'h0100, 8'h01, 8'h02, 8'h00, n, ak);
    check(ak == 8'h10, "R3 frozen ack", ak, 8'h10);
    check(ld_pc == 16'h4010, "R3 vector", ld_pc, 16'h4010);
    irq_req = 8'h00; cyc(1);
    // bit 0 is captured now; clear it through service
    do_entry(16'h2000, 16'h0100, 8'h01, 8'h02, 8'h00, n, ak);
    check(ak == 8'h01, "R3 next winner", ak, 8'h01);
  endtask

  task automatic t_mask;
    int n; logic [7:0] ak;
    irq_req = 8'h00; mask = 1'b1; cyc(2);
    irq_req = 8'h20; cyc(3);
    check(!pending, "R4 masked", pending, 0);
    mask = 1'b0; cyc(1);
    check(pending, "R4 unmasked", pending, 1);
    mask = 1'b1; irq_req = 8'h22; cyc(2);
    check(pending, "R4 held while masked", pending, 1);
    mask = 1'b0; cyc(3);
    do_entry(16'h3000, 16'h0200, 8'h00, 8'h00, 8'h00, n, ak);
    check(ak == 8'h02, "R4 rearbitrated", ak, 8'h02);
    irq_req = 8'h00; cyc(2);
    do_entry(16'h3000, 16'h0200, 8'h00, 8'h00, 8'h00, n, ak);
    check(ak == 8'h20, "R4 remaining", ak, 8'h20);
  endtask

  task automatic t_rti;
    int n;
    mem[16'h0301] = 8'hC3; mem[16'h0302] = 8'h11; mem[16'h0303] = 8'h22;
    mem[16'h0304] = 8'h9A; mem[16'h0305] = 8'hBC;
    irq_req = 8'h00;
    @(negedge clk); cpu_sp = 16'h0300; rti = 1'b1;
    @(negedge clk); rti = 1'b0; n = 1;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == 6, "R9 cycles", n, 6);
    check(ld_ccr == 8'hC3 && ld_a == 8'h11 && ld_x == 8'h22, "R9 regs", {ld_ccr, ld_a, ld_x}, 24'hC31122);
    check(ld_pc == 16'h9ABC && ld_sp == 16'h0305, "R9 pc sp", ld_pc, 16'h9ABC);
  endtask

  task automatic t_busy;
    int n;
    mem[16'hFFFE] = 8'h77; mem[16'hFFFF] = 8'h66;
    irq_req = 8'h01; mask = 1'b0; cyc(1);
    @(negedge clk); cpu_pc = 16'h5000; cpu_sp = 16'h0400; take = 1'b1;
    #1 irq_req = irq_req & ~ack;
    @(negedge clk); take = 1'b0; rti = 1'b1; cpu_sp = 16'h0800;
    @(negedge clk); rti = 1'b0; n = 2;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == 8 && ld_pc == 16'h7766 && ld_sp == 16'h03FB, "R10 ignored", ld_sp, 16'h03FB);
    cyc(3);
    check(!busy, "R10 no restart", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; irq_req = 8'h00; mask = 1'b1; take = 1'b0; rti = 1'b0;
    cpu_pc = '0; cpu_sp = '0; cpu_a = '0; cpu_x = '0; cpu_ccr = '0;
    cyc(3);
    t_reset;
    rst_n = 1'b1; cyc(1);
    t_reset;
    t_no_pending;
    t_priority_entry;
    t_freeze;
    t_mask;
    t_rti;
    t_busy;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule